// File: doc/BRIEF.md
# DRAM Power-Mode Sequencer

This block sits beside the command scheduler of a memory controller for a low-power DDR memory without an on-die DLL. It owns the clock-enable pin, the gate of the clock sent to the memory, an enable for the controller-side clock domain, and a small command port. Over that port it issues power-down entry and exit, self-refresh entry and exit, and auto-refresh. While the memory is awake and needs no refresh, it hands the command bus to the scheduler through a ready flag.

There are six graded power modes, numbered 0 to 5:

| Mode | Memory state | Memory clock | Refresh |
|------|--------------|--------------|---------|
| 0 | Awake | Running | Issued by this block |
| 1 | Power-down | Running | Woken briefly for each refresh |
| 2 | Power-down | Gated | Clock re-opened briefly for each refresh |
| 3 | Self-refresh | Running | Kept by the memory itself |
| 4 | Self-refresh | Gated | Kept by the memory itself |
| 5 | Self-refresh | Gated, and the controller-side clock is also stopped | Kept by the memory itself |

In automatic operation, an idle counter steps the mode one level deeper each time it reaches a programmable threshold. Any access request pulls the block back to mode 0. Software can instead pin any mode through a force enable and a forced mode value.

Every change of mode passes through the awake state. The block first wakes the memory and waits out the wake-up time, then enters the new mode. Around every clock-enable edge in a gated mode, the memory clock runs for a fixed guard time. A decision is taken only while the block is resting, so a request for a new mode that arrives during a refresh or an exit waits for that sequence to finish.

Top module: `dram_pwr_seq`

## Requirements
- R1: After reset the block is in mode 0 with clock enable high, both clock enables high, command NOP (code 0), and scheduler ready high while no refresh is due and the target mode is 0.
- R2: In mode 0 the refresh counter counts up to the interval. The refresh is then due: ready drops and a single REF (code 5) is issued. Consecutive REFs are exactly interval+2 cycles apart.
- R3: In mode 1 the block issues power-down entry (code 1) and drops clock enable while the memory clock keeps running. When a refresh falls due it issues power-down exit (code 2), then REF exactly PD_WAKE+1 cycles after the exit, then power-down entry again in the very next cycle.
- R4: In mode 2 the memory clock is gated exactly GATE_CYC+1 cycles after the power-down entry cycle. For each refresh the clock is re-opened exactly GATE_CYC cycles before the power-down exit command. The memory clock is never gated while clock enable is high.
- R5: Modes 3 to 5 issue self-refresh entry (code 3) with clock enable low, and no other command is issued until self-refresh exit (code 4). Mode 3 keeps the memory clock running. Modes 4 and 5 gate it. Only mode 5 drops the controller-side clock enable.
- R6: While force enable is high, the target mode is the forced value, and values 6 and 7 are treated as 5. While force enable is low, the target comes from the automatic ladder.
- R7: In automatic operation, each time the idle counter reaches the threshold with no request, the mode moves exactly one step deeper, up to 5. A request sets the target back to 0.
- R8: On return to mode 0, scheduler ready rises exactly PD_WAKE+1 cycles after a power-down exit command, or exactly SR_WAKE+1 cycles after a self-refresh exit command.
- R9: A mode change requested during a refresh sequence waits. After a power-down exit for refresh, the REF is still issued before the entry command of the new mode.
- R10: The refresh counter is held at zero during self-refresh and restarts from zero after self-refresh exit. The first REF follows the exit command by exactly interval+2 cycles when that is later than the wake-up time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | An access request is pending |
| force_en_i | input | 1 | Software force enable |
| force_mode_i | input | 3 | Software forced mode (values above 5 read as 5) |
| idle_thresh_i | input | IDLE_W | Idle cycles before each step down the ladder |
| refi_i | input | REFI_W | Refresh interval in cycles (at least 1) |
| cke_o | output | 1 | Memory clock enable |
| mem_clk_en_o | output | 1 | Enable of the memory clock gate |
| ctl_clk_en_o | output | 1 | Enable of the controller-side clock domain |
| cmd_o | output | 3 | Command: 0 NOP, 1 PD entry, 2 PD exit, 3 SR entry, 4 SR exit, 5 REF |
| mode_o | output | 3 | Mode currently being held or entered |
| sched_rdy_o | output | 1 | Scheduler may use the memory |

## Verification
Outputs are decoded from registered state, so a command is visible in the cycle its state is entered. The expected distances are:
- REF after power-down exit: PD_WAKE+1 cycles.
- Ready after power-down exit: PD_WAKE+1 cycles.
- Ready after self-refresh exit: SR_WAKE+1 cycles.
- Clock gate after power-down entry: GATE_CYC+1 cycles.
- Clock-enable rise after the clock gate re-opens: GATE_CYC cycles.
- REF-to-REF in mode 0: interval+2 cycles.

The bench samples at the falling edge and counts falling edges from the cycle where the triggering command was seen to the cycle where the result appears, then compares the count with these sums.

// File: rtl/dps_pkg.sv
// Shared types of the DRAM power-mode sequencer.
// Assumes modes are numbered 0 (awake) to 5 (deepest).
package dps_pkg;

    // Command codes seen by the memory command mux
    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_PDE = 3'd1,
        CMD_PDX = 3'd2,
        CMD_SRE = 3'd3,
        CMD_SRX = 3'd4,
        CMD_REF = 3'd5
    } dps_cmd_e;

    // Sequencer phases
    typedef enum logic [2:0] {
        ST_AWAKE,
        ST_REFRESH,
        ST_DROP_CKE,
        ST_GATE_WAIT,
        ST_ASLEEP,
        ST_UNGATE_WAIT,
        ST_RAISE_CKE,
        ST_WAKE_WAIT
    } dps_state_e;

    localparam logic [2:0] MODE_DEEPEST = 3'd5;

    // True for the self-refresh family of modes
    function automatic logic mode_is_sr(input logic [2:0] m);
        return m >= 3'd3;
    endfunction

    // True for modes that stop the memory clock
    function automatic logic mode_gates(input logic [2:0] m);
        return (m == 3'd2) || (m >= 3'd4);
    endfunction

endpackage

// File: rtl/dps_refresh_timer.sv
// Refresh-interval timer.
// Counts cycles since the last refresh and flags a due refresh once the
// programmed interval is reached. Held at zero during self-refresh.
// Assumes refi_i >= 1.
module dps_refresh_timer #(
    parameter int REFI_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REFI_W-1:0] refi_i,
    input  logic              suspend_i,
    input  logic              ref_issued_i,
    output logic              due_o
);

    logic [REFI_W-1:0] cnt_q;

    // Count up to the interval; clear on refresh or while suspended
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (suspend_i || ref_issued_i) begin
            cnt_q <= '0;
        end else if (cnt_q < refi_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Refresh is due once the interval is reached, never in self-refresh
    assign due_o = !suspend_i && (cnt_q >= refi_i);

endmodule

// File: rtl/dps_mode_select.sv
// Target-mode selection.
// Runs the idle ladder in automatic operation and applies the software
// force. The ladder only steps while the sequencer rests in the mode the
// ladder currently asks for, so no level is skipped.
module dps_mode_select #(
    parameter int IDLE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              force_en_i,
    input  logic [2:0]        force_mode_i,
    input  logic [IDLE_W-1:0] idle_thresh_i,
    input  logic              settled_i,
    input  logic [2:0]        cur_mode_i,
    output logic [2:0]        target_o
);
    import dps_pkg::*;

    logic [2:0]        auto_q;
    logic [IDLE_W-1:0] idle_q;
    logic [2:0]        forced;

    // Idle ladder: a request resets, a threshold hit steps one mode deeper
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            auto_q <= 3'd0;
            idle_q <= '0;
        end else if (req_i) begin
            auto_q <= 3'd0;
            idle_q <= '0;
        end else if (!force_en_i && settled_i && (cur_mode_i == auto_q)
                     && (auto_q < MODE_DEEPEST)) begin
            if (idle_q >= idle_thresh_i) begin
                auto_q <= auto_q + 3'd1;
                idle_q <= '0;
            end else begin
                idle_q <= idle_q + 1'b1;
            end
        end
    end

    // Clamp out-of-range forced values to the deepest mode
    always_comb begin
        forced = (force_mode_i > MODE_DEEPEST) ? MODE_DEEPEST : force_mode_i;
    end

    // The software force wins over the ladder
    assign target_o = force_en_i ? forced : auto_q;

endmodule

// File: rtl/dps_fsm.sv
// Power-state sequencer.
// Walks the memory between the awake state and the power-down or
// self-refresh state of the current mode, with clock-gate guard times and
// wake-up holds. Decisions are taken only in the awake and asleep phases,
// so a new target waits for any sequence in flight. Outputs are decoded
// from registered state. Assumes PD_WAKE >= 1 and SR_WAKE >= 1.
module dps_fsm #(
    parameter int GATE_CYC = 2,
    parameter int PD_WAKE  = 2,
    parameter int SR_WAKE  = 200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] target_i,
    input  logic       ref_due_i,
    output logic       cke_o,
    output logic       mem_clk_en_o,
    output logic       ctl_clk_en_o,
    output logic [2:0] cmd_o,
    output logic [2:0] cur_mode_o,
    output logic       awake_o,
    output logic       settled_o,
    output logic       in_sr_o,
    output logic       ref_issued_o
);
    import dps_pkg::*;

    localparam int MAX_A  = (GATE_CYC > PD_WAKE) ? GATE_CYC : PD_WAKE;
    localparam int MAX_C  = (MAX_A > SR_WAKE) ? MAX_A : SR_WAKE;
    localparam int CNT_W  = $clog2(MAX_C + 1);
    localparam int GATE_L = (GATE_CYC > 0) ? GATE_CYC - 1 : 0;
    localparam int PD_L   = (PD_WAKE > 0) ? PD_WAKE - 1 : 0;
    localparam int SR_L   = (SR_WAKE > 0) ? SR_WAKE - 1 : 0;
    localparam bit HAS_GUARD = (GATE_CYC > 0);

    dps_state_e       state_q;
    logic [2:0]       cur_q;
    logic             trip_q;
    logic [CNT_W-1:0] cnt_q;
    logic             need_guard;

    // A guard window applies only to clock-gating modes with a non-zero guard
    always_comb begin
        need_guard = HAS_GUARD && mode_gates(cur_q);
    end

    // Phase sequencing, mode bookkeeping and the shared delay counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_AWAKE;
            cur_q   <= 3'd0;
            trip_q  <= 1'b0;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                ST_AWAKE: begin
                    if (ref_due_i) begin
                        state_q <= ST_REFRESH;
                    end else if (target_i != 3'd0) begin
                        cur_q   <= target_i;
                        state_q <= ST_DROP_CKE;
                    end
                end
                ST_REFRESH: begin
                    trip_q <= 1'b0;
                    if (trip_q && (target_i == cur_q)) begin
                        state_q <= ST_DROP_CKE;
                    end else begin
                        cur_q   <= 3'd0;
                        state_q <= ST_AWAKE;
                    end
                end
                ST_DROP_CKE: begin
                    if (need_guard) begin
                        cnt_q   <= CNT_W'(GATE_L);
                        state_q <= ST_GATE_WAIT;
                    end else begin
                        state_q <= ST_ASLEEP;
                    end
                end
                ST_GATE_WAIT: begin
                    if (cnt_q == '0) begin
                        state_q <= ST_ASLEEP;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                ST_ASLEEP: begin
                    if ((target_i != cur_q) ||
                        (ref_due_i && !mode_is_sr(cur_q))) begin
                        trip_q <= (target_i == cur_q);
                        if (need_guard) begin
                            cnt_q   <= CNT_W'(GATE_L);
                            state_q <= ST_UNGATE_WAIT;
                        end else begin
                            state_q <= ST_RAISE_CKE;
                        end
                    end
                end
                ST_UNGATE_WAIT: begin
                    if (cnt_q == '0) begin
                        state_q <= ST_RAISE_CKE;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                ST_RAISE_CKE: begin
                    cnt_q   <= mode_is_sr(cur_q) ? CNT_W'(SR_L) : CNT_W'(PD_L);
                    state_q <= ST_WAKE_WAIT;
                end
                ST_WAKE_WAIT: begin
                    if (cnt_q != '0) begin
                        cnt_q <= cnt_q - 1'b1;
                    end else if (trip_q) begin
                        state_q <= ST_REFRESH;
                    end else begin
                        cur_q   <= 3'd0;
                        state_q <= ST_AWAKE;
                    end
                end
                default: state_q <= ST_AWAKE;
            endcase
        end
    end

    // Clock enable is high in every phase where the memory is awake
    always_comb begin
        cke_o = (state_q == ST_AWAKE) || (state_q == ST_REFRESH) ||
                (state_q == ST_RAISE_CKE) || (state_q == ST_WAKE_WAIT);
    end

    // Clock gates close only while resting in a gating mode
    always_comb begin
        mem_clk_en_o = !((state_q == ST_ASLEEP) && mode_gates(cur_q));
        ctl_clk_en_o = !((state_q == ST_ASLEEP) && (cur_q == MODE_DEEPEST));
    end

    // Command decode from the phase and the mode family
    always_comb begin
        case (state_q)
            ST_REFRESH:   cmd_o = CMD_REF;
            ST_DROP_CKE:  cmd_o = mode_is_sr(cur_q) ? CMD_SRE : CMD_PDE;
            ST_RAISE_CKE: cmd_o = mode_is_sr(cur_q) ? CMD_SRX : CMD_PDX;
            default:      cmd_o = CMD_NOP;
        endcase
    end

    // Status toward the timer, the ladder and the top
    always_comb begin
        in_sr_o = mode_is_sr(cur_q) &&
                  (state_q inside {ST_DROP_CKE, ST_GATE_WAIT, ST_ASLEEP,
                                   ST_UNGATE_WAIT, ST_RAISE_CKE});
        settled_o    = (state_q == ST_AWAKE) || (state_q == ST_ASLEEP);
        awake_o      = (state_q == ST_AWAKE);
        ref_issued_o = (state_q == ST_REFRESH);
        cur_mode_o   = cur_q;
    end

endmodule

// File: rtl/dram_pwr_seq.sv
// DRAM power-mode sequencer, top level.
// Joins the refresh timer, the target-mode selector and the phase
// sequencer, and grants the command bus to the scheduler while the memory
// is awake with nothing due. Assumes refi_i >= 1 and small guard times.
module dram_pwr_seq #(
    parameter int GATE_CYC = 2,
    parameter int PD_WAKE  = 2,
    parameter int SR_WAKE  = 200,
    parameter int IDLE_W   = 16,
    parameter int REFI_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              force_en_i,
    input  logic [2:0]        force_mode_i,
    input  logic [IDLE_W-1:0] idle_thresh_i,
    input  logic [REFI_W-1:0] refi_i,
    output logic              cke_o,
    output logic              mem_clk_en_o,
    output logic              ctl_clk_en_o,
    output logic [2:0]        cmd_o,
    output logic [2:0]        mode_o,
    output logic              sched_rdy_o
);

    logic       ref_due;
    logic       in_sr;
    logic       ref_issued;
    logic       settled;
    logic       awake;
    logic [2:0] target;
    logic [2:0] cur_mode;

    dps_refresh_timer #(.REFI_W(REFI_W)) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .refi_i       (refi_i),
        .suspend_i    (in_sr),
        .ref_issued_i (ref_issued),
        .due_o        (ref_due)
    );

    dps_mode_select #(.IDLE_W(IDLE_W)) u_select (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_i         (req_i),
        .force_en_i    (force_en_i),
        .force_mode_i  (force_mode_i),
        .idle_thresh_i (idle_thresh_i),
        .settled_i     (settled),
        .cur_mode_i    (cur_mode),
        .target_o      (target)
    );

    dps_fsm #(
        .GATE_CYC (GATE_CYC),
        .PD_WAKE  (PD_WAKE),
        .SR_WAKE  (SR_WAKE)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .target_i     (target),
        .ref_due_i    (ref_due),
        .cke_o        (cke_o),
        .mem_clk_en_o (mem_clk_en_o),
        .ctl_clk_en_o (ctl_clk_en_o),
        .cmd_o        (cmd_o),
        .cur_mode_o   (cur_mode),
        .awake_o      (awake),
        .settled_o    (settled),
        .in_sr_o      (in_sr),
        .ref_issued_o (ref_issued)
    );

    // Grant the bus only when awake, nothing due and no deeper mode wanted
    always_comb begin
        sched_rdy_o = awake && !ref_due && (target == 3'd0);
        mode_o      = cur_mode;
    end

endmodule

// File: rtl/dps_checker.sv
// Protocol checker for the DRAM power-mode sequencer, bound to the top.
// Watches only the ports and keeps its own counters for guard windows
// and wake-up holds.
module dps_checker #(
    parameter int GATE_CYC = 2,
    parameter int PD_WAKE  = 2,
    parameter int SR_WAKE  = 200
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cke_o,
    input logic       mem_clk_en_o,
    input logic       ctl_clk_en_o,
    input logic [2:0] cmd_o,
    input logic [2:0] mode_o,
    input logic       sched_rdy_o
);
    logic [15:0] clk_on_cnt;
    logic [15:0] cke_lo_cnt;
    logic [15:0] wake_cnt;
    logic        last_sr;
    logic        in_sr;

    // Consecutive cycles the memory clock ran and clock enable was low
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_on_cnt <= '0;
            cke_lo_cnt <= '0;
        end else begin
            clk_on_cnt <= !mem_clk_en_o ? '0 :
                          (clk_on_cnt == 16'hFFFF) ? clk_on_cnt : clk_on_cnt + 16'd1;
            cke_lo_cnt <= cke_o ? '0 :
                          (cke_lo_cnt == 16'hFFFF) ? cke_lo_cnt : cke_lo_cnt + 16'd1;
        end
    end

    // Cycles since the last exit command, and its family
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wake_cnt <= 16'hFFFF;
            last_sr  <= 1'b0;
        end else if (cmd_o == 3'd2 || cmd_o == 3'd4) begin
            wake_cnt <= '0;
            last_sr  <= (cmd_o == 3'd4);
        end else if (wake_cnt != 16'hFFFF) begin
            wake_cnt <= wake_cnt + 16'd1;
        end
    end

    // Self-refresh residency as seen on the command port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_sr <= 1'b0;
        end else if (cmd_o == 3'd3) begin
            in_sr <= 1'b1;
        end else if (cmd_o == 3'd4) begin
            in_sr <= 1'b0;
        end
    end

    AST_RDY_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
        sched_rdy_o |-> (cke_o && mem_clk_en_o && mode_o == 3'd0));  // R1
    AST_GATE_LOW_CKE: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_clk_en_o |-> !cke_o);  // R4
    AST_GATE_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_clk_en_o) |-> (int'(cke_lo_cnt) >= GATE_CYC + 1));  // R4
    AST_UNGATE_BEFORE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke_o) |-> (int'(clk_on_cnt) >= GATE_CYC));  // R4
    AST_SR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        in_sr |-> (cmd_o == 3'd0 || cmd_o == 3'd4));  // R5
    AST_CTL_DEEPEST: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_clk_en_o |-> (mode_o == 3'd5 && !mem_clk_en_o));  // R5
    AST_WAKE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        sched_rdy_o |-> (int'(wake_cnt) >= (last_sr ? SR_WAKE : PD_WAKE)));  // R8

endmodule

bind dram_pwr_seq dps_checker #(
    .GATE_CYC (GATE_CYC),
    .PD_WAKE  (PD_WAKE),
    .SR_WAKE  (SR_WAKE)
) u_dps_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .cke_o        (cke_o),
    .mem_clk_en_o (mem_clk_en_o),
    .ctl_clk_en_o (ctl_clk_en_o),
    .cmd_o        (cmd_o),
    .mode_o       (mode_o),
    .sched_rdy_o  (sched_rdy_o)
);

// File: tb/dram_pwr_seq_test.sv
`timescale 1ns/1ps
// Directed bench for the DRAM power-mode sequencer.
module dram_pwr_seq_test;

    localparam int GATE = 2;
    localparam int PDW  = 2;
    localparam int SRW  = 200;
    localparam logic [2:0] C_NOP = 3'd0, C_PDE = 3'd1, C_PDX = 3'd2,
                           C_SRE = 3'd3, C_SRX = 3'd4, C_REF = 3'd5;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req;
    logic        force_en;
    logic [2:0]  force_mode;
    logic [15:0] idle_thresh;
    logic [15:0] refi;
    logic        cke, mclk_en, cclk_en, rdy;
    logic [2:0]  cmd, mode;

    int nchk = 0;
    int nerr = 0;

    always #2.5 clk = ~clk;

    dram_pwr_seq #(.GATE_CYC(GATE), .PD_WAKE(PDW), .SR_WAKE(SRW)) uut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .force_en_i(force_en),
        .force_mode_i(force_mode), .idle_thresh_i(idle_thresh), .refi_i(refi),
        .cke_o(cke), .mem_clk_en_o(mclk_en), .ctl_clk_en_o(cclk_en),
        .cmd_o(cmd), .mode_o(mode), .sched_rdy_o(rdy)
    );

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; req = 1'b0; force_en = 1'b0; force_mode = 3'd0;
        idle_thresh = 16'hFFFF; refi = 16'd1000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Falling edges until cmd equals c; -1 on timeout
    task automatic wait_cmd(input logic [2:0] c, input int limit, output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (cmd != c && n < limit);
        if (cmd != c) n = -1;
    endtask

    // Falling edges until any command other than NOP
    task automatic wait_any(input int limit, output logic [2:0] c, output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (cmd == C_NOP && n < limit);
        c = cmd;
    endtask

    task automatic wait_clk(input logic v, input int limit, output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (mclk_en != v && n < limit);
        if (mclk_en != v) n = -1;
    endtask

    task automatic wait_rdy(input int limit, output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (!rdy && n < limit);
        if (!rdy) n = -1;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 cke", cke, 1); chk("R1 mem clk", mclk_en, 1);
        chk("R1 ctl clk", cclk_en, 1); chk("R1 cmd", cmd, C_NOP);
        chk("R1 mode", mode, 0); chk("R1 ready", rdy, 1);
    endtask

    task automatic t_mode0_ref();
        int n;
        do_reset(); refi = 16'd40;
        wait_cmd(C_REF, 200, n);
        chk("R2 ready low at REF", rdy, 0);
        chk("R2 cke at REF", cke, 1);
        wait_cmd(C_REF, 200, n);
        chk("R2 REF spacing", n, 42);
    endtask

    task automatic t_mode1();
        int n;
        do_reset(); refi = 16'd60; force_en = 1'b1; force_mode = 3'd1;
        wait_cmd(C_PDE, 20, n);
        chk("R3 PD entry seen", n > 0, 1);
        @(negedge clk);
        chk("R3 cke low", cke, 0); chk("R3 clock runs", mclk_en, 1);
        chk("R3 mode", mode, 1); chk("R3 ready low", rdy, 0);
        wait_cmd(C_PDX, 200, n);
        chk("R3 PD exit for refresh", n > 0, 1);
        wait_cmd(C_REF, 20, n);
        chk("R3 REF after exit", n, PDW + 1);
        wait_cmd(C_PDE, 20, n);
        chk("R3 re-entry", n, 1);
    endtask

    task automatic t_mode2();
        int n;
        do_reset(); refi = 16'd80; force_en = 1'b1; force_mode = 3'd2;
        wait_cmd(C_PDE, 20, n);
        wait_clk(1'b0, 20, n);
        chk("R4 gate after entry", n, GATE + 1);
        chk("R4 cke low while gated", cke, 0);
        wait_clk(1'b1, 300, n);
        chk("R4 cke still low at ungate", cke, 0);
        wait_cmd(C_PDX, 20, n);
        chk("R4 ungate lead", n, GATE);
        wait_cmd(C_REF, 20, n);
        chk("R4 REF after exit", n, PDW + 1);
        wait_cmd(C_PDE, 20, n);
        chk("R4 re-entry", n, 1);
        wait_clk(1'b0, 20, n);
        chk("R4 regate", n, GATE + 1);
    endtask

    task automatic t_self_ref();
        int n, extra, first_rdy;
        do_reset(); refi = 16'd300; force_en = 1'b1; force_mode = 3'd3;
        wait_cmd(C_SRE, 20, n);
        @(negedge clk);
        chk("R5 mode 3 cke", cke, 0); chk("R5 mode 3 clock runs", mclk_en, 1);
        chk("R5 mode 3 ctl clock", cclk_en, 1);
        extra = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (cmd != C_NOP) extra++;
        end
        chk("R5 silent in self-refresh", extra, 0);
        force_mode = 3'd0;
        wait_cmd(C_SRX, 20, n);
        first_rdy = -1; n = 0;
        do begin
            @(negedge clk); n++;
            if (rdy && first_rdy < 0) first_rdy = n;
        end while (cmd != C_REF && n < 1000);
        chk("R8 ready after SR exit", first_rdy, SRW + 1);
        chk("R10 first REF after SR exit", n, 302);
    endtask

    task automatic t_gated_sr();
        int n;
        do_reset(); force_en = 1'b1; force_mode = 3'd7;
        wait_cmd(C_SRE, 20, n);
        wait_clk(1'b0, 20, n);
        chk("R6 clamp to mode 5", mode, 5);
        chk("R5 mode 5 ctl clock off", cclk_en, 0);
        chk("R5 mode 5 cke", cke, 0);
        force_mode = 3'd4;
        wait_cmd(C_SRE, 500, n);
        wait_clk(1'b0, 20, n);
        chk("R6 forced mode 4", mode, 4);
        chk("R5 mode 4 clock gated", n, GATE + 1);
        chk("R5 mode 4 ctl clock on", cclk_en, 1);
    endtask

    task automatic t_auto();
        int n, prev, bad;
        do_reset(); idle_thresh = 16'd8; refi = 16'hFFFF;
        req = 1'b1;
        repeat (5) @(negedge clk);
        chk("R7 request holds mode 0", mode, 0);
        req = 1'b0;
        prev = 0; bad = 0; n = 0;
        do begin
            @(negedge clk); n++;
            if (mode != 0 && mode != prev) begin
                if (mode != prev + 1) bad++;
                prev = mode;
            end
        end while (mode != 5 && n < 5000);
        chk("R7 ladder one step at a time", bad, 0);
        chk("R7 deepest reached", mode, 5);
        req = 1'b1;
        wait_rdy(600, n);
        chk("R7 request wakes", n > 0, 1);
        chk("R7 mode 0 after request", mode, 0);
    endtask

    task automatic t_pd_wake();
        int n;
        do_reset(); idle_thresh = 16'd8;
        wait_cmd(C_PDE, 50, n);
        repeat (2) @(negedge clk);
        req = 1'b1;
        wait_cmd(C_PDX, 20, n);
        wait_rdy(20, n);
        chk("R8 ready after PD exit", n, PDW + 1);
    endtask

    task automatic t_defer();
        int n;
        logic [2:0] c;
        do_reset(); refi = 16'd60; force_en = 1'b1; force_mode = 3'd1;
        wait_cmd(C_PDX, 300, n);
        force_mode = 3'd3;
        wait_any(20, c, n);
        chk("R9 REF still issued", c, C_REF);
        chk("R9 REF timing", n, PDW + 1);
        wait_any(20, c, n);
        chk("R9 new mode after REF", c, C_SRE);
    endtask

    initial begin
        t_reset();
        t_mode0_ref();
        t_mode1();
        t_mode2();
        t_self_ref();
        t_gated_sr();
        t_auto();
        t_pd_wake();
        t_defer();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule